// File: doc/BRIEF.md
# Two-Way Host/Coprocessor Mailbox

This block carries short messages between a host processor and a coprocessor. Each direction has one 16-bit data slot. The host fills the slot that travels toward the coprocessor, and the coprocessor fills the slot that travels back. Each side sees its own four-entry register window through a select/strobe bus:

- a send slot, which is write-only;
- a receive slot, which is read-only;
- a status word;
- a control word, in which writing a one clears the matching bit.

Direction is enforced in hardware. Reading a slot from the sending side, or reading the control word, returns an all-ones pattern. A write aimed at a read-only location is dropped.

Delivery raises a level interrupt toward the receiver, together with a one-cycle wake pulse. The wake pulse lets a sleeping coprocessor resume. Consumption, meaning a read of a full slot, raises a level interrupt back toward the sender. A full flag tracks each slot. Writing a slot that is still full replaces its data and latches a sticky overrun flag in the writer's status.

Top module: `dual_mailbox`

## Requirements
- R1: After synchronous reset, both status words read 0, both interrupts and both wake outputs are low, and both slots hold 0.
- R2: A write to select 0 (send slot) stores the data and sets that slot's full flag. The other side reads exactly that value at select 1 (receive slot).
- R3: A read at select 0 or select 3 returns 16'hFFFF and changes no state.
- R4: A write at select 1 or select 2 is dropped. Slot data, flags and interrupts stay unchanged.
- R5: Each write to the send slot drives the receiver's wake output high for exactly the following cycle. The receiver's interrupt goes high in that same cycle.
- R6: A read of the receive slot while it is full clears the full flag and raises the sender's interrupt. A read while it is empty returns the held value and raises nothing.
- R7: Interrupt causes are levels that stay set until the owning side writes select 3. Bit 0 clears its delivery cause and bit 1 clears its consumption cause. A new event in the same cycle as a clear wins.
- R8: A write to a full slot that is not being read in that cycle replaces the data and sets the writer's overrun flag. The flag stays set until the writer writes select 3 with bit 2 set.
- R9: If a write and a read of the same slot coincide, the reader gets the previous value and the slot stays full with the new value. No overrun is flagged, and both interrupts rise.
- R10: Status layout: bit 0 is receive slot full, bit 1 is send slot full, bit 2 is overrun, bit 3 is delivery cause pending, and bit 4 is consumption cause pending. The upper bits read 0.
- R11: Both directions behave identically, with the roles of host and coprocessor swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 2 | Host register select |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data (combinational) |
| h_irq | output | 1 | Host interrupt, level |
| h_wake | output | 1 | One-cycle pulse after a coprocessor send |
| c_sel | input | 2 | Coprocessor register select |
| c_wr | input | 1 | Coprocessor write strobe |
| c_rd | input | 1 | Coprocessor read strobe |
| c_wdata | input | 16 | Coprocessor write data |
| c_rdata | output | 16 | Coprocessor read data (combinational) |
| c_irq | output | 1 | Coprocessor interrupt, level |
| c_wake | output | 1 | One-cycle pulse after a host send |

## Verification
The hardest situations to reach are those in which both sides act on the same slot in the same clock cycle:

- a send colliding with the consuming read;
- a clear of an interrupt cause colliding with the event that sets it again.

Separate per-side sequences never line these up. The bench therefore uses a shared-cycle scheme: it presets both buses at one falling edge, samples the combinational read data shortly after, and lets a single rising edge commit both operations. Status words are then read back to show that the overrun bit stayed clear and that the interrupt survived the clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DEF_DATA_W = 16;

    // Register select codes seen by each side
    typedef enum logic [1:0] {
        SEL_SEND = 2'd0,   // write-only data slot toward the far side
        SEL_RECV = 2'd1,   // read-only data slot from the far side
        SEL_STAT = 2'd2,   // status word, read-only
        SEL_CTRL = 2'd3    // write-one-to-clear control, write-only
    } sel_e;

    // Status word, bit 0 is the LSB of the packed struct
    typedef struct packed {
        logic ack_pend;   // bit 4
        logic data_pend;  // bit 3
        logic overrun;    // bit 2
        logic send_full;  // bit 1
        logic recv_full;  // bit 0
    } stat_t;

    // Clear requests decoded from a control write
    typedef struct packed {
        logic ovr;        // bit 2
        logic ack;        // bit 1
        logic data;       // bit 0
    } clr_t;

    localparam int STAT_W = $bits(stat_t);
    localparam int CLR_W  = $bits(clr_t);

    function automatic clr_t decode_clear(input logic hit, input logic [CLR_W-1:0] bits);
        clr_t c;
        c = hit ? clr_t'(bits) : '0;
        return c;
    endfunction

endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              clr_data_irq,
    input  logic              clr_ack_irq,
    input  logic              clr_ovr,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              overrun,
    output logic              data_irq,
    output logic              ack_irq,
    output logic              wake
);

    logic consume;
    logic clobber;

    always_comb begin
        consume = rd_en && full;
        clobber = wr_en && full && !rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data     <= '0;
            full     <= 1'b0;
            overrun  <= 1'b0;
            data_irq <= 1'b0;
            ack_irq  <= 1'b0;
            wake     <= 1'b0;
        end else begin
            wake <= wr_en;
            if (wr_en) begin
                data <= wr_data;
            end
            if (wr_en) begin
                full <= 1'b1;
            end else if (consume) begin
                full <= 1'b0;
            end
            if (clobber) begin
                overrun <= 1'b1;
            end else if (clr_ovr) begin
                overrun <= 1'b0;
            end
            if (wr_en) begin
                data_irq <= 1'b1;
            end else if (clr_data_irq) begin
                data_irq <= 1'b0;
            end
            if (consume) begin
                ack_irq <= 1'b1;
            end else if (clr_ack_irq) begin
                ack_irq <= 1'b0;
            end
        end
    end

    AST_FULL_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (full && data == $past(wr_data)));  // R2
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wake && data_irq));  // R5
    AST_CONSUME_ACK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && full && !wr_en) |=> (!full && ack_irq));  // R6
    AST_EMPTY_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !full && !wr_en && !ack_irq) |=> !ack_irq);  // R6
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (data_irq && !clr_data_irq) |=> data_irq);  // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !clr_ovr) |=> overrun);  // R8
    AST_NO_OVR_ON_PASS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && !overrun) |=> !overrun);  // R9
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(data));  // R4

endmodule

// File: rtl/mbx_side_port.sv
module mbx_side_port
    import mbx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    // toward the channel this side sends on
    output logic              send_wr,
    output logic [DATA_W-1:0] send_data,
    output logic              clr_ack,
    output logic              clr_ovr,
    input  logic              send_full,
    input  logic              send_ovr,
    input  logic              send_ack_irq,
    // toward the channel this side receives on
    output logic              recv_rd,
    output logic              clr_data,
    input  logic [DATA_W-1:0] recv_data,
    input  logic              recv_full,
    input  logic              recv_data_irq
);

    localparam logic [DATA_W-1:0] INVALID = '1;
    localparam int PAD_W = DATA_W - STAT_W;

    sel_e  sel_q;
    stat_t st;
    clr_t  clr;

    always_comb begin
        sel_q     = sel_e'(sel);
        send_wr   = wr && (sel_q == SEL_SEND);
        recv_rd   = rd && (sel_q == SEL_RECV);
        send_data = wdata;
        clr       = decode_clear(wr && (sel_q == SEL_CTRL), wdata[CLR_W-1:0]);
        clr_data  = clr.data;
        clr_ack   = clr.ack;
        clr_ovr   = clr.ovr;

        st.recv_full = recv_full;
        st.send_full = send_full;
        st.overrun   = send_ovr;
        st.data_pend = recv_data_irq;
        st.ack_pend  = send_ack_irq;

        irq = recv_data_irq | send_ack_irq;

        unique case (sel_q)
            SEL_RECV: rdata = recv_data;
            SEL_STAT: rdata = {{PAD_W{1'b0}}, st};
            default:  rdata = INVALID;
        endcase
    end

    AST_BAD_READ_INVALID: assert property (@(posedge clk) disable iff (rst)
        (rd && (sel == 2'd0 || sel == 2'd3)) |-> (rdata == INVALID));  // R3
    AST_BAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr && (sel == 2'd1 || sel == 2'd2)) |-> !(send_wr || clr_data || clr_ack || clr_ovr));  // R4

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox
    import mbx_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        h_sel,
    input  logic              h_wr,
    input  logic              h_rd,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              h_irq,
    output logic              h_wake,
    input  logic [1:0]        c_sel,
    input  logic              c_wr,
    input  logic              c_rd,
    input  logic [DATA_W-1:0] c_wdata,
    output logic [DATA_W-1:0] c_rdata,
    output logic              c_irq,
    output logic              c_wake
);

    localparam int SIDES = 2;  // index 0 = host, 1 = coprocessor

    // per-side bus
    logic [SIDES-1:0][1:0]        p_sel;
    logic [SIDES-1:0]             p_wr, p_rd, p_irq;
    logic [SIDES-1:0][DATA_W-1:0] p_wdata, p_rdata;

    // channel s is written by side s and read by the other side
    logic [SIDES-1:0]             s_wr, s_rd, s_clr_data, s_clr_ack, s_clr_ovr;
    logic [SIDES-1:0][DATA_W-1:0] s_wdata;
    logic [SIDES-1:0][DATA_W-1:0] ch_data;
    logic [SIDES-1:0]             ch_full, ch_ovr, ch_dirq, ch_airq, ch_wake;

    always_comb begin
        p_sel[0] = h_sel;   p_wr[0] = h_wr;   p_rd[0] = h_rd;   p_wdata[0] = h_wdata;
        p_sel[1] = c_sel;   p_wr[1] = c_wr;   p_rd[1] = c_rd;   p_wdata[1] = c_wdata;
        h_rdata = p_rdata[0];
        c_rdata = p_rdata[1];
        h_irq   = p_irq[0];
        c_irq   = p_irq[1];
        h_wake  = ch_wake[1];
        c_wake  = ch_wake[0];
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int FAR = SIDES - 1 - s;

        mbx_side_port #(.DATA_W(DATA_W)) port_i (
            .clk           (clk),
            .rst           (rst),
            .sel           (p_sel[s]),
            .wr            (p_wr[s]),
            .rd            (p_rd[s]),
            .wdata         (p_wdata[s]),
            .rdata         (p_rdata[s]),
            .irq           (p_irq[s]),
            .send_wr       (s_wr[s]),
            .send_data     (s_wdata[s]),
            .clr_ack       (s_clr_ack[s]),
            .clr_ovr       (s_clr_ovr[s]),
            .send_full     (ch_full[s]),
            .send_ovr      (ch_ovr[s]),
            .send_ack_irq  (ch_airq[s]),
            .recv_rd       (s_rd[s]),
            .clr_data      (s_clr_data[s]),
            .recv_data     (ch_data[FAR]),
            .recv_full     (ch_full[FAR]),
            .recv_data_irq (ch_dirq[FAR])
        );

        mbx_channel #(.DATA_W(DATA_W)) chan_i (
            .clk          (clk),
            .rst          (rst),
            .wr_en        (s_wr[s]),
            .wr_data      (s_wdata[s]),
            .rd_en        (s_rd[FAR]),
            .clr_data_irq (s_clr_data[FAR]),
            .clr_ack_irq  (s_clr_ack[s]),
            .clr_ovr      (s_clr_ovr[s]),
            .data         (ch_data[s]),
            .full         (ch_full[s]),
            .overrun      (ch_ovr[s]),
            .data_irq     (ch_dirq[s]),
            .ack_irq      (ch_airq[s]),
            .wake         (ch_wake[s])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!h_irq && !c_irq && !h_wake && !c_wake));  // R1
    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!h_irq && !c_wr && !c_rd) |=> !h_irq);  // R11

endmodule

// File: tb/dual_mailbox_tb_top.sv
`timescale 1ns/1ps
module dual_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  h_sel, c_sel;
    logic        h_wr, h_rd, c_wr, c_rd;
    logic [15:0] h_wdata, c_wdata, h_rdata, c_rdata;
    logic        h_irq, c_irq, h_wake, c_wake;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;  // 50 MHz

    dual_mailbox dut_i (
        .clk(clk), .rst(rst),
        .h_sel(h_sel), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .h_irq(h_irq), .h_wake(h_wake),
        .c_sel(c_sel), .c_wr(c_wr), .c_rd(c_rd), .c_wdata(c_wdata),
        .c_rdata(c_rdata), .c_irq(c_irq), .c_wake(c_wake)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        h_sel = 2'd0; h_wr = 1'b0; h_rd = 1'b0; h_wdata = 16'h0;
        c_sel = 2'd0; c_wr = 1'b0; c_rd = 1'b0; c_wdata = 16'h0;
    endtask

    task automatic set_h(input logic wr, input logic rd, input logic [1:0] sel, input logic [15:0] wd);
        h_wr = wr; h_rd = rd; h_sel = sel; h_wdata = wd;
    endtask

    task automatic set_c(input logic wr, input logic rd, input logic [1:0] sel, input logic [15:0] wd);
        c_wr = wr; c_rd = rd; c_sel = sel; c_wdata = wd;
    endtask

    // commit the preset bus values at one rising edge, return at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic h_write(input logic [1:0] sel, input logic [15:0] wd);
        set_h(1'b1, 1'b0, sel, wd); step();
    endtask
    task automatic c_write(input logic [1:0] sel, input logic [15:0] wd);
        set_c(1'b1, 1'b0, sel, wd); step();
    endtask
    task automatic h_read(input logic [1:0] sel, output logic [15:0] v);
        set_h(1'b0, 1'b1, sel, 16'h0); #1 v = h_rdata; step();
    endtask
    task automatic c_read(input logic [1:0] sel, output logic [15:0] v);
        set_c(1'b0, 1'b1, sel, 16'h0); #1 v = c_rdata; step();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 host irq", {15'h0, h_irq}, 16'h0);
        check("R1 copro irq", {15'h0, c_irq}, 16'h0);
        check("R1 wake", {14'h0, h_wake, c_wake}, 16'h0);
        h_read(2'd2, v); check("R1 host status", v, 16'h0000);
        c_read(2'd2, v); check("R1 copro status", v, 16'h0000);
        h_read(2'd1, v); check("R1 host recv slot", v, 16'h0000);
    endtask

    task automatic t_host_to_copro();
        logic [15:0] v;
        h_write(2'd0, 16'h1234);
        check("R5 c_wake after send", {15'h0, c_wake}, 16'h1);
        check("R5 c_irq after send", {15'h0, c_irq}, 16'h1);
        check("R5 h_irq untouched", {15'h0, h_irq}, 16'h0);
        h_read(2'd2, v); check("R10 host status send_full", v, 16'h0002);
        check("R5 c_wake single cycle", {15'h0, c_wake}, 16'h0);
        c_read(2'd2, v); check("R10 copro status full+pend", v, 16'h0009);
        c_read(2'd1, v); check("R2 copro gets data", v, 16'h1234);
        check("R6 h_irq on consume", {15'h0, h_irq}, 16'h1);
        h_read(2'd2, v); check("R6 host status ack pending", v, 16'h0010);
        c_read(2'd2, v); check("R7 delivery cause still set", v, 16'h0008);
        c_write(2'd3, 16'h0001);
        check("R7 c_irq cleared", {15'h0, c_irq}, 16'h0);
        check("R7 h_irq unaffected by far clear", {15'h0, h_irq}, 16'h1);
        h_write(2'd3, 16'h0002);
        check("R7 h_irq cleared", {15'h0, h_irq}, 16'h0);
    endtask

    task automatic t_bad_access();
        logic [15:0] v;
        h_read(2'd0, v); check("R3 host read send slot", v, 16'hFFFF);
        h_read(2'd3, v); check("R3 host read ctrl", v, 16'hFFFF);
        c_read(2'd0, v); check("R3 copro read send slot", v, 16'hFFFF);
        h_read(2'd2, v); check("R3 no side effect of bad read", v, 16'h0000);
        h_write(2'd1, 16'hAAAA);
        h_write(2'd2, 16'h001F);
        check("R4 no irq from dropped write", {14'h0, h_irq, c_irq}, 16'h0);
        h_read(2'd1, v); check("R4 host recv slot unchanged", v, 16'h0000);
        c_read(2'd2, v); check("R4 copro status unchanged", v, 16'h0000);
        c_write(2'd1, 16'h5555);
        c_read(2'd1, v); check("R4 copro recv slot unchanged", v, 16'h1234);
        check("R6 empty read raises nothing", {15'h0, h_irq}, 16'h0);
    endtask

    task automatic t_copro_to_host();
        logic [15:0] v;
        c_write(2'd0, 16'hBEEF);
        check("R11 h_wake after copro send", {15'h0, h_wake}, 16'h1);
        check("R11 h_irq after copro send", {15'h0, h_irq}, 16'h1);
        h_read(2'd2, v); check("R11 host status recv", v, 16'h0009);
        h_read(2'd1, v); check("R11 host gets data", v, 16'hBEEF);
        check("R11 c_irq on consume", {15'h0, c_irq}, 16'h1);
        c_read(2'd2, v); check("R11 copro status ack", v, 16'h0010);
        h_write(2'd3, 16'h0001);
        c_write(2'd3, 16'h0002);
        check("R11 both irqs cleared", {14'h0, h_irq, c_irq}, 16'h0);
    endtask

    task automatic t_overrun();
        logic [15:0] v;
        h_write(2'd0, 16'h1111);
        h_write(2'd0, 16'h2222);
        h_read(2'd2, v); check("R8 overrun flagged", v, 16'h0006);
        c_read(2'd1, v); check("R8 newest data kept", v, 16'h2222);
        h_read(2'd2, v); check("R8 overrun sticky after read", v, 16'h0014);
        h_write(2'd3, 16'h0002);
        h_read(2'd2, v); check("R8 ack clear leaves overrun", v, 16'h0004);
        h_write(2'd3, 16'h0004);
        h_read(2'd2, v); check("R8 overrun cleared", v, 16'h0000);
        c_write(2'd3, 16'h0001);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        h_write(2'd0, 16'h3333);
        set_h(1'b1, 1'b0, 2'd0, 16'h4444);
        set_c(1'b0, 1'b1, 2'd1, 16'h0);
        #1 v = c_rdata;
        step();
        check("R9 reader sees old value", v, 16'h3333);
        h_read(2'd2, v); check("R9 full, ack, no overrun", v, 16'h0012);
        c_read(2'd2, v); check("R9 copro full and pending", v, 16'h0009);
        // clear racing a new delivery: set wins
        set_c(1'b1, 1'b0, 2'd3, 16'h0001);
        set_h(1'b1, 1'b0, 2'd0, 16'h5555);
        step();
        check("R7 set wins over clear", {15'h0, c_irq}, 16'h1);
        h_read(2'd2, v); check("R9 second write overruns", v, 16'h0016);
        c_read(2'd1, v); check("R2 latest data", v, 16'h5555);
        c_write(2'd3, 16'h0001);
        h_write(2'd3, 16'h0006);
        check("R7 all clear", {14'h0, h_irq, c_irq}, 16'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_to_copro();
        t_bad_access();
        t_copro_to_host();
        t_overrun();
        t_collide();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule